// File: doc/BRIEF.md
# Quadrature Position Counter with Byte-Wide Register Port

This block follows one incremental encoder axis with a 24-bit up/down position count. The two encoder phases and an external snapshot strobe each pass through a two-stage synchronizer. A small phase tracker then turns each valid Gray-code step into a count-up or count-down pulse. The counting resolution is x1, x2 or x4, and a register setting selects it.

Software reaches the block through an 8-bit port with two addresses. A byte written to the control address is a command. Its two top bits select one of four targets: the action register, which carries pulse-style actions; the input-control register; the output-control register; or the quadrature-mode register. Bytes written to the data address fill a preset register. Bytes read from the data address come from an output latch. Both transfers move least significant byte first, stepped by an internal byte pointer.

A typical set-up sequence is:
1. Master reset.
2. Enable the inputs.
3. Select x4 mode.
4. Clear the count.

The usual read sequence is a combined pointer-reset-and-latch command followed by three data reads. A free-running timer can instead pulse the strobe input, which loads the latch directly.

Two state machines govern the block:
- The phase tracker has the states `PH_00`, `PH_10`, `PH_11` and `PH_01`, named after the A/B levels it last sampled. Its transitions are of three kinds: forward (00→10→11→01→00), reverse (the opposite direction) and invalid (both bits change at once). An invalid transition moves the state but does not count.
- The command decoder selects one of `SEL_ACTION`, `SEL_INPUT`, `SEL_OUTPUT` or `SEL_QUAD` on each control write.

Top module: `qenc_counter`

## Requirements
- R1: After reset, and after a master reset (action byte with bit 5 set, i.e. 0x20), the count, preset, output latch and byte pointer are zero. Counting is disabled, the quadrature mode is off, and both the carry and borrow flags are clear.
- R2: Bits 7:6 of a control byte select the target: 00 selects the action register, 01 input control, 10 output control and 11 quadrature mode. In input control, bit 3 enables counting (0x68 enables it). In quadrature mode, bits 1:0 select 00 off, 01 x1, 10 x2 or 11 x4 (0xC3 selects x4). A write to output control changes no count, latch, flag or mode state.
- R3: In an action byte, bit 0 resets the byte pointer, bit 1 copies the count into the output latch, bit 2 clears the count and both flags, and bit 3 loads the preset into the count. Bits written together act in the same cycle. A load overrides a clear for the count value, but the flags are still cleared. A latch captures the count as it was before that cycle's update.
- R4: Every data-port read or write uses the byte selected by the pointer and then advances the pointer. Byte 0 holds bits 7:0, byte 1 bits 15:8 and byte 2 bits 23:16. After byte 2 the pointer wraps back to byte 0.
- R5: Three preset bytes written, then loaded, latched and read back, return exactly the bytes written.
- R6: In x4 mode, every forward A/B step (00→10→11→01→00, written as {A,B}) adds one to the count, and every reverse step subtracts one.
- R7: In x2 mode, only steps that change A count. In x1 mode, only steps between 00 and 10 count. In off mode, nothing counts.
- R8: A transition in which A and B change together never changes the count.
- R9: While counting is disabled, encoder activity leaves the count unchanged.
- R10: The count wraps modulo 2^24. The carry flag sets on an up-step from 0xFFFFFF, and the borrow flag sets on a down-step from 0. Both flags stay set until a clear or a master reset.
- R11: A rising edge on the strobe input copies the count into the output latch without any bus command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ctrl_sel | input | 1 | 1 addresses the control port, 0 the data port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Output-latch byte selected by the byte pointer |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| latch_strobe | input | 1 | Snapshot request (asynchronous, rising edge) |
| carry_flag | output | 1 | Sticky wrap-up flag |
| borrow_flag | output | 1 | Sticky wrap-down flag |

## Verification
The in-line properties check several rules on every cycle:
- No A/B transition that changes both bits produces a step.
- Without a clear or load, the count moves by at most one per cycle.
- A disabled counter holds its count.
- The carry and borrow flags set on the wrapping step.
- A load takes the preset.
- The pointer wraps after byte 2.
- A master reset leaves every register at zero.
- Any latch request captures the count of the previous cycle.

Some behaviours only the bench scenarios can show, because they are compared with an independent count model:
- Resolution in x1, x2 and x4 over long random walks.
- The byte order of a preset round trip.
- A latch taken by the strobe surviving later motion.
- Output-control writes having no effect.
- Combined action bytes resolving as specified.

// File: rtl/qc_pkg.sv
package qc_pkg;

    typedef enum logic [1:0] {
        SEL_ACTION = 2'b00,
        SEL_INPUT  = 2'b01,
        SEL_OUTPUT = 2'b10,
        SEL_QUAD   = 2'b11
    } cmd_sel_e;

    typedef enum logic [1:0] {
        QM_OFF = 2'b00,
        QM_X1  = 2'b01,
        QM_X2  = 2'b10,
        QM_X4  = 2'b11
    } quad_mode_e;

    // state name = last sampled {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    localparam int ACT_PTR_RST = 0;
    localparam int ACT_LATCH   = 1;
    localparam int ACT_CLEAR   = 2;
    localparam int ACT_LOAD    = 3;
    localparam int ACT_MRST    = 5;
    localparam int IN_ENABLE   = 3;

endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/qc_quad_decoder.sv
module qc_quad_decoder
    import qc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a,
    input  logic       b,
    input  logic       enable,
    input  quad_mode_e mode,
    output logic       step_up,
    output logic       step_dn
);

    phase_e     phase_q;
    logic [1:0] cur;
    logic       fwd;
    logic       rev;
    logic       a_moved;
    logic       x1_pair;
    logic       qual;

    assign cur = {a, b};

    // state register: always follows the sampled phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_00;
        end else begin
            phase_q <= phase_e'(cur);
        end
    end

    // outputs: classify the transition out of the current state
    always_comb begin
        fwd = 1'b0;
        rev = 1'b0;
        unique case (phase_q)
            PH_00: begin fwd = (cur == 2'b10); rev = (cur == 2'b01); end
            PH_10: begin fwd = (cur == 2'b11); rev = (cur == 2'b00); end
            PH_11: begin fwd = (cur == 2'b01); rev = (cur == 2'b10); end
            PH_01: begin fwd = (cur == 2'b00); rev = (cur == 2'b11); end
        endcase

        a_moved = cur[1] ^ phase_q[1];
        x1_pair = ((phase_q == PH_00) && (cur == 2'b10)) ||
                  ((phase_q == PH_10) && (cur == 2'b00));

        unique case (mode)
            QM_OFF: qual = 1'b0;
            QM_X1:  qual = x1_pair;
            QM_X2:  qual = a_moved;
            QM_X4:  qual = 1'b1;
        endcase

        step_up = enable & qual & fwd;
        step_dn = enable & qual & rev;
    end

    // R8
    double_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur[1] != phase_q[1]) && (cur[0] != phase_q[0])) |-> (!step_up && !step_dn));

    // R7
    x1_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == QM_X1) && (step_up || step_dn)) |-> ((phase_q == PH_00) || (phase_q == PH_10)));

endmodule

// File: rtl/qc_count_core.sv
module qc_count_core #(
    parameter int COUNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_up,
    input  logic               step_dn,
    input  logic               do_clear,
    input  logic               do_load,
    input  logic [COUNT_W-1:0] preset,
    output logic [COUNT_W-1:0] count,
    output logic               carry,
    output logic               borrow
);

    localparam logic [COUNT_W-1:0] CNT_MAX = '1;
    localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

    logic quiet;
    assign quiet = !do_clear && !do_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            carry  <= 1'b0;
            borrow <= 1'b0;
        end else if (do_load) begin
            count <= preset;
            if (do_clear) begin
                carry  <= 1'b0;
                borrow <= 1'b0;
            end
        end else if (do_clear) begin
            count  <= '0;
            carry  <= 1'b0;
            borrow <= 1'b0;
        end else if (step_up) begin
            count <= count + CNT_ONE;
            if (count == CNT_MAX) carry <= 1'b1;
        end else if (step_dn) begin
            count <= count - CNT_ONE;
            if (count == '0) borrow <= 1'b1;
        end
    end

    // R6
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ((count == $past(count)) || (count == $past(count) + CNT_ONE) ||
                   (count == $past(count) - CNT_ONE)));

    // R10
    carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && step_up && (count == CNT_MAX)) |=> (carry && (count == '0)));

    // R10
    borrow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && step_dn && (count == '0)) |=> (borrow && (count == CNT_MAX)));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (count == $past(preset)));

endmodule

// File: rtl/qc_bus_regs.sv
module qc_bus_regs
    import qc_pkg::*;
#(
    parameter int COUNT_W = 24,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_sel,
    input  logic               wr,
    input  logic               rd,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               strobe_sync,
    input  logic [COUNT_W-1:0] count,
    output logic [BYTE_W-1:0]  rdata,
    output logic [COUNT_W-1:0] preset,
    output logic               in_en,
    output quad_mode_e         qmode,
    output logic               do_clear,
    output logic               do_load
);

    localparam int NBYTES = COUNT_W / BYTE_W;
    localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBYTES - 1);

    logic [PTR_W-1:0]   ptr;
    logic [COUNT_W-1:0] olatch;
    logic               strobe_q;
    logic               strobe_rise;
    cmd_sel_e           sel;
    logic               cmd_wr, data_wr, data_rd, data_acc;
    logic               act, mrst, ptr_rst, latch_now;
    logic               unused_bits;

    assign sel         = cmd_sel_e'(wdata[BYTE_W-1:BYTE_W-2]);
    assign cmd_wr      = wr && ctrl_sel;
    assign data_wr     = wr && !ctrl_sel;
    assign data_rd     = rd && !ctrl_sel;
    assign data_acc    = data_wr || data_rd;
    assign act         = cmd_wr && (sel == SEL_ACTION);
    assign mrst        = act && wdata[ACT_MRST];
    assign ptr_rst     = act && wdata[ACT_PTR_RST];
    assign strobe_rise = strobe_sync && !strobe_q;
    assign latch_now   = (act && wdata[ACT_LATCH]) || strobe_rise;
    assign do_clear    = (act && wdata[ACT_CLEAR]) || mrst;
    assign do_load     = act && wdata[ACT_LOAD] && !mrst;
    assign unused_bits = ^{wdata[4], wdata[2:0], rd && ctrl_sel};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_sync;
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_en <= 1'b0;
            qmode <= QM_OFF;
        end else if (mrst) begin
            in_en <= 1'b0;
            qmode <= QM_OFF;
        end else if (cmd_wr) begin
            unique case (sel)
                SEL_INPUT:  in_en <= wdata[IN_ENABLE];
                SEL_QUAD:   qmode <= quad_mode_e'(wdata[1:0]);
                SEL_ACTION,
                SEL_OUTPUT: ;
            endcase
        end
    end

    // byte pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (mrst || ptr_rst) begin
            ptr <= '0;
        end else if (data_acc) begin
            ptr <= (ptr == PTR_LAST) ? '0 : ptr + PTR_W'(1);
        end
    end

    // preset byte lanes and output latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset <= '0;
            olatch <= '0;
        end else if (mrst) begin
            preset <= '0;
            olatch <= '0;
        end else begin
            if (data_wr) begin
                for (int i = 0; i < NBYTES; i++) begin
                    if (ptr == PTR_W'(i)) preset[i*BYTE_W +: BYTE_W] <= wdata;
                end
            end
            if (latch_now) olatch <= count;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (ptr == PTR_W'(i)) rdata = olatch[i*BYTE_W +: BYTE_W];
        end
    end

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !mrst && !ptr_rst && (ptr == PTR_LAST)) |=> (ptr == '0));

    // R1
    mrst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> ((ptr == '0) && (preset == '0) && (olatch == '0) && !in_en && (qmode == QM_OFF)));

    // R11
    latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_now && !mrst) |=> (olatch == $past(count)));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qc_pkg::*;
#(
    parameter int COUNT_W     = 24,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ctrl_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              latch_strobe,
    output logic              carry_flag,
    output logic              borrow_flag
);

    logic [2:0]         sync_q;
    logic               step_up, step_dn;
    logic               do_clear, do_load;
    logic               in_en;
    quad_mode_e         qmode;
    logic [COUNT_W-1:0] preset;
    logic [COUNT_W-1:0] count;

    qc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({latch_strobe, enc_a, enc_b}),
        .q     (sync_q)
    );

    qc_quad_decoder i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .a       (sync_q[1]),
        .b       (sync_q[0]),
        .enable  (in_en),
        .mode    (qmode),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    qc_count_core #(.COUNT_W(COUNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .do_clear (do_clear),
        .do_load  (do_load),
        .preset   (preset),
        .count    (count),
        .carry    (carry_flag),
        .borrow   (borrow_flag)
    );

    qc_bus_regs #(.COUNT_W(COUNT_W), .BYTE_W(BYTE_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_sel    (bus_ctrl_sel),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .wdata       (bus_wdata),
        .strobe_sync (sync_q[2]),
        .count       (count),
        .rdata       (bus_rdata),
        .preset      (preset),
        .in_en       (in_en),
        .qmode       (qmode),
        .do_clear    (do_clear),
        .do_load     (do_load)
    );

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_en && !do_clear && !do_load) |=> $stable(count));

endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       enc_a = 1'b0, enc_b = 1'b0, strobe = 1'b0;
    logic       carry, borrow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [23:0] m_cnt = '0;
    logic        m_carry = 1'b0, m_borrow = 1'b0;
    logic [1:0]  ph = 2'b00;
    logic [1:0]  m_mode = 2'b00;
    logic        m_en = 1'b0;

    always #2.5 clk = ~clk;

    qenc_counter i_qenc_counter (
        .clk(clk), .rst_n(rst_n), .bus_ctrl_sel(sel), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .enc_a(enc_a), .enc_b(enc_b),
        .latch_strobe(strobe), .carry_flag(carry), .borrow_flag(borrow)
    );

    function automatic int pos_of(input logic [1:0] p);
        case (p)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    // expected step from the requirements (R6, R7, R8)
    function automatic int exp_delta(input logic [1:0] mode, input logic [1:0] o, input logic [1:0] n);
        int d;
        bit q;
        d = (pos_of(n) - pos_of(o) + 4) % 4;
        if (d == 0 || d == 2) return 0;
        case (mode)
            2'b11: q = 1'b1;
            2'b10: q = (o[1] != n[1]);
            2'b01: q = ((o == 2'b00) && (n == 2'b10)) || ((o == 2'b10) && (n == 2'b00));
            default: q = 1'b0;
        endcase
        if (!q) return 0;
        return (d == 1) ? 1 : -1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic c, input logic [7:0] v);
        @(negedge clk);
        sel = c; wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] v);
        @(negedge clk);
        sel = 1'b0; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic read3(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        bus_write(1'b1, 8'h01);
        bus_read(b0); bus_read(b1); bus_read(b2);
        v = {b2, b1, b0};
    endtask

    task automatic write_preset(input logic [23:0] v);
        bus_write(1'b1, 8'h01);
        bus_write(1'b0, v[7:0]);
        bus_write(1'b0, v[15:8]);
        bus_write(1'b0, v[23:16]);
    endtask

    task automatic latch_check(input string tag);
        logic [23:0] v;
        bus_write(1'b1, 8'h03);
        read3(v);
        check(tag, {8'h0, v}, {8'h0, m_cnt});
        check({tag, " carry"}, {31'h0, carry}, {31'h0, m_carry});
        check({tag, " borrow"}, {31'h0, borrow}, {31'h0, m_borrow});
    endtask

    // kind: 0 forward, 1 reverse, 2 both bits
    task automatic enc_step(input int kind);
        logic [1:0] n;
        int d;
        case (kind)
            0: case (ph) 2'b00: n = 2'b10; 2'b10: n = 2'b11; 2'b11: n = 2'b01; default: n = 2'b00; endcase
            1: case (ph) 2'b00: n = 2'b01; 2'b01: n = 2'b11; 2'b11: n = 2'b10; default: n = 2'b00; endcase
            default: n = ~ph;
        endcase
        d = m_en ? exp_delta(m_mode, ph, n) : 0;
        ph = n;
        enc_a = n[1]; enc_b = n[0];
        if (d == 1) begin
            if (m_cnt == 24'hFFFFFF) m_carry = 1'b1;
            m_cnt = m_cnt + 24'd1;
        end else if (d == -1) begin
            if (m_cnt == 24'h0) m_borrow = 1'b1;
            m_cnt = m_cnt - 24'd1;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic walk(input int n);
        for (int i = 0; i < n; i++) begin
            int r;
            r = $urandom_range(0, 7);
            enc_step(r < 4 ? 0 : (r < 7 ? 1 : 2));
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        bus_write(1'b1, {6'b110000, m});
        m_mode = m;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] v, snap;
        logic [7:0]  b0, b1, b2, b3;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read3(v);
        check("R1 latch after reset", {8'h0, v}, 32'h0);
        check("R1 flags after reset", {30'h0, carry, borrow}, 32'h0);

        // R9 mode selected but not enabled
        set_mode(2'b11);
        for (int i = 0; i < 6; i++) enc_step(0);
        latch_check("R9 disabled no count");

        // R2 enable and clear, R6 x4 walk with R8 doubles
        bus_write(1'b1, 8'h68); m_en = 1'b1;
        bus_write(1'b1, 8'h04); m_cnt = '0; m_carry = 0; m_borrow = 0;
        for (int k = 0; k < 4; k++) begin
            walk(60);
            latch_check("R6 x4 walk");
        end
        for (int i = 0; i < 6; i++) enc_step(2);
        latch_check("R8 double transitions ignored");

        // R7 x2 and x1
        set_mode(2'b10);
        walk(80);
        latch_check("R7 x2 walk");
        set_mode(2'b01);
        walk(80);
        latch_check("R7 x1 walk");
        set_mode(2'b00);
        walk(20);
        latch_check("R7 off mode");
        set_mode(2'b11);

        // R2 output-control write has no effect
        bus_write(1'b1, 8'hBF);
        latch_check("R2 output ctrl ignored");
        enc_step(0);
        latch_check("R2 mode kept after output ctrl");

        // R5 preset round trip, R4 byte order
        write_preset(24'h3CA55A);
        bus_write(1'b1, 8'h09); m_cnt = 24'h3CA55A;
        bus_write(1'b1, 8'h03);
        bus_read(b0); bus_read(b1); bus_read(b2);
        check("R5 byte0", {24'h0, b0}, 32'h5A);
        check("R5 byte1", {24'h0, b1}, 32'hA5);
        check("R5 byte2", {24'h0, b2}, 32'h3C);
        // R4 read wrap
        bus_read(b3);
        check("R4 read wraps to byte0", {24'h0, b3}, 32'h5A);

        // R4 write wrap: 4th byte overwrites byte 0
        bus_write(1'b1, 8'h01);
        bus_write(1'b0, 8'h11); bus_write(1'b0, 8'h22);
        bus_write(1'b0, 8'h33); bus_write(1'b0, 8'h44);
        bus_write(1'b1, 8'h09); m_cnt = 24'h332244;
        latch_check("R4 write wrap");

        // R10 carry and borrow
        write_preset(24'hFFFFFF);
        bus_write(1'b1, 8'h09); m_cnt = 24'hFFFFFF;
        enc_step(0);
        latch_check("R10 carry wrap");
        enc_step(0);
        latch_check("R10 carry sticky");
        enc_step(1); enc_step(1);
        latch_check("R10 borrow wrap");
        bus_write(1'b1, 8'h04); m_cnt = '0; m_carry = 0; m_borrow = 0;
        latch_check("R10 clear drops flags");

        // R3 combined latch + clear + load
        walk(15);
        snap = m_cnt;
        write_preset(24'h0BEEF1);
        bus_write(1'b1, 8'h0E);
        m_cnt = 24'h0BEEF1; m_carry = 0; m_borrow = 0;
        read3(v);
        check("R3 latch takes old count", {8'h0, v}, {8'h0, snap});
        latch_check("R3 load beats clear");

        // R3 latch + clear
        snap = m_cnt;
        bus_write(1'b1, 8'h06); m_cnt = '0;
        read3(v);
        check("R3 latch with clear", {8'h0, v}, {8'h0, snap});
        latch_check("R3 clear result");

        // R11 external strobe
        walk(12);
        snap = m_cnt;
        @(negedge clk); strobe = 1'b1;
        repeat (3) @(negedge clk); strobe = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 5; i++) enc_step(0);
        read3(v);
        check("R11 strobe snapshot", {8'h0, v}, {8'h0, snap});

        // R1 master reset
        write_preset(24'h123456);
        enc_step(0); enc_step(0);
        bus_write(1'b1, 8'h20);
        m_cnt = '0; m_carry = 0; m_borrow = 0; m_en = 0; m_mode = 2'b00;
        read3(v);
        check("R1 latch zero after master reset", {8'h0, v}, 32'h0);
        for (int i = 0; i < 4; i++) enc_step(0);
        latch_check("R1 counting off after master reset");
        bus_write(1'b1, 8'h68); m_en = 1'b1;
        for (int i = 0; i < 4; i++) enc_step(0);
        latch_check("R1 mode off after master reset");
        bus_write(1'b1, 8'h09);
        latch_check("R1 preset zero after master reset");
        set_mode(2'b11);
        walk(40);
        latch_check("R6 x4 after re-init");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule